// File: doc/BRIEF.md
# Crosspoint configuration controller

This block is the digital control plane of a 16-output by 16-input crosspoint switch. It keeps a first-rank register of 80 bits, split into 16 output slots of 5 bits. Each slot holds a 4-bit input-select code and one output-enable bit. The first rank changes only on the falling edge of `clk`, and only while the active-low `ce_n` is low. Software-side logic can fill the register in two ways. It can stream all 80 bits through the serial input, which makes the register one long chain with a serial output at its far end. It can also write a single slot, chosen by a 4-bit address, through the 5-bit parallel data port.

A second rank of level-sensitive latches sits between the register and the switch array. These latches follow the first rank while `upd_n` and `ce_n` are both low, and they hold otherwise. This lets a whole new configuration be staged first and then applied in one step. The latched slots are decoded into 256 one-hot switch enables, one per (output, input) pair. An asynchronous active-low reset turns every output off without touching any other bit.

The load logic decides one operation for each falling edge: HOLD when `ce_n` is high; SHIFT when `ce_n` is low and `load_par` is low; WRITE when `ce_n` is low and `load_par` is high. There is no stored sequencing. The operation is re-chosen at every edge, so any operation can follow any other.

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: While `ce_n` is high, a falling clock edge changes nothing: `sdo` and `sw_en` stay as they were, whatever the other inputs do.
- R2: In SHIFT, each falling edge moves `sdi` into the chain. After 80 shifts, the first bit shifted in has become the enable of output 15, and the last bit has become select bit 0 of output 0. Each slot is passed in the order enable, select bit 3, bit 2, bit 1, bit 0.
- R3: Each SHIFT edge loads `sdo` with the bit that leaves the far end of the chain. A bit presented on `sdi` at one SHIFT edge therefore appears on `sdo` right after the 80th later SHIFT edge. `sdo` does not change on HOLD or WRITE edges.
- R4: In WRITE, the falling edge stores `pdata` into the slot numbered by `paddr` (`paddr[0]` is the LSB). `pdata[3:0]` is the select code, with bit 0 as the LSB, and `pdata[4]` is the enable. The other 15 slots keep their values.
- R5: The update latches are transparent while `upd_n` and `ce_n` are both low, so `sw_en` follows the first rank. While `upd_n` is high, `sw_en` is unaffected by any change to the first rank.
- R6: Driving `rst_n` low clears every output enable at once, without a clock edge. The select latches and the first-rank register are left unchanged. A later update with no reload restores the earlier configuration.
- R7: `sw_en[16*o+i]` is 1 exactly when output o is enabled and its latched select code equals i. At most one bit per output is set.
- R8: While `rst_n` is low, the enables stay cleared even if the update latches are transparent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Load clock; the first rank acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low clear of all output enables |
| ce_n | input | 1 | Active-low chip enable for loading and updating |
| upd_n | input | 1 | Active-low update; makes the second-rank latches transparent |
| load_par | input | 1 | 0 selects serial shifting, 1 selects addressed slot writes |
| sdi | input | 1 | Serial data input |
| pdata | input | 5 | Parallel slot data: [3:0] select code, [4] enable |
| paddr | input | 4 | Output slot address for parallel writes |
| sdo | output | 1 | Serial data output, the far end of the chain |
| sw_en | output | 256 | Switch enables, bit 16*output+input |

## Verification
An error in the chain ordering shows up on `sw_en` at the first update after a full serial load, as the wrong output/input pair being switched. It also shows on `sdo` 80 shift edges after the bad bit went in. A slot write that spills into a neighbour shows up as a stray or missing enable at the next update. A latch that leaks while `upd_n` is high changes `sw_en` within the same clock cycle as the first-rank edge that feeds it. A reset that clears too much shows only later, when an update without reload fails to bring back the old selects.

// File: rtl/xcfg_pkg.sv
package xcfg_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_WRITE = 2'd2
    } xcfg_op_e;
endpackage

// File: rtl/xcfg_op_decode.sv
module xcfg_op_decode
    import xcfg_pkg::*;
(
    input  logic     ce_n,
    input  logic     load_par,
    output xcfg_op_e op
);
    always_comb begin
        unique case ({ce_n, load_par})
            2'b00:   op = OP_SHIFT;
            2'b01:   op = OP_WRITE;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/xcfg_shift_rank.sv
module xcfg_shift_rank
    import xcfg_pkg::*;
#(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned SEL_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  xcfg_op_e                   op,
    input  logic                       sdi,
    input  logic [SEL_W:0]             pdata,
    input  logic [$clog2(N_OUT)-1:0]   paddr,
    output logic [N_OUT*(SEL_W+1)-1:0] chain,
    output logic                       sdo
);
    localparam int unsigned SLOT_W  = SEL_W + 1;
    localparam int unsigned CHAIN_W = N_OUT * SLOT_W;
    localparam int unsigned ADDR_W  = $clog2(N_OUT);

    logic [CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0] chain_d;
    logic               sdo_q;

    always_comb begin
        chain_d = chain_q;
        unique case (op)
            OP_SHIFT: chain_d = {chain_q[CHAIN_W-2:0], sdi};
            OP_WRITE: begin
                for (int s = 0; s < int'(N_OUT); s++) begin
                    if (paddr == ADDR_W'(s)) chain_d[s*SLOT_W +: SLOT_W] = pdata;
                end
            end
            OP_HOLD:  chain_d = chain_q;
            default:  chain_d = chain_q;
        endcase
    end

    always_ff @(negedge clk) begin
        chain_q <= chain_d;
        if (op == OP_SHIFT) sdo_q <= chain_q[CHAIN_W-1];
    end

    assign chain = chain_q;
    assign sdo   = sdo_q;

    AST_HOLD_FREEZES_RANK: assert property (@(negedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> $stable(chain_q)); // R1

    generate
        for (genvar s = 0; s < int'(N_OUT); s++) begin : g_iso
            AST_SLOT_ISOLATED: assert property (@(negedge clk) disable iff (!rst_n)
                (op == OP_WRITE && paddr != ADDR_W'(s)) |=> $stable(chain_q[s*SLOT_W +: SLOT_W])); // R4
        end
    endgenerate
endmodule

// File: rtl/xcfg_hold_latch.sv
module xcfg_hold_latch #(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned SEL_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_n,
    input  logic                       upd_n,
    input  logic [N_OUT*(SEL_W+1)-1:0] chain,
    output logic [N_OUT*SEL_W-1:0]     lat_sel,
    output logic [N_OUT-1:0]           lat_en
);
    localparam int unsigned SLOT_W = SEL_W + 1;

    logic open_w;
    assign open_w = !ce_n && !upd_n;

    always_latch begin
        if (open_w) begin
            for (int o = 0; o < int'(N_OUT); o++) begin
                lat_sel[o*SEL_W +: SEL_W] = chain[o*SLOT_W +: SEL_W];
            end
        end
    end

    always_latch begin
        if (!rst_n) begin
            lat_en = '0;
        end else if (open_w) begin
            for (int o = 0; o < int'(N_OUT); o++) begin
                lat_en[o] = chain[o*SLOT_W + SEL_W];
            end
        end
    end

    always_comb begin
        if (!rst_n) begin
            AST_RESET_CLEARS_EN: assert (lat_en == '0); // R6
        end
    end

    AST_LATCH_HOLDS: assert property (@(negedge clk) disable iff (!rst_n)
        ($past(upd_n) && upd_n) |-> $stable(lat_sel)); // R5
endmodule

// File: rtl/xcfg_switch_decode.sv
module xcfg_switch_decode #(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned N_IN  = 16,
    parameter int unsigned SEL_W = 4
) (
    input  logic [N_OUT*SEL_W-1:0] lat_sel,
    input  logic [N_OUT-1:0]       lat_en,
    output logic [N_OUT*N_IN-1:0]  sw_en
);
    generate
        for (genvar o = 0; o < int'(N_OUT); o++) begin : g_out
            for (genvar i = 0; i < int'(N_IN); i++) begin : g_in
                assign sw_en[o*N_IN + i] = lat_en[o] && (lat_sel[o*SEL_W +: SEL_W] == SEL_W'(i));
            end
            always_comb begin
                AST_ONE_SOURCE: assert ($onehot0(sw_en[o*N_IN +: N_IN])); // R7
            end
        end
    endgenerate
endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl
    import xcfg_pkg::*;
#(
    parameter int unsigned N_OUT = 16,
    parameter int unsigned N_IN  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ce_n,
    input  logic                     upd_n,
    input  logic                     load_par,
    input  logic                     sdi,
    input  logic [$clog2(N_IN):0]    pdata,
    input  logic [$clog2(N_OUT)-1:0] paddr,
    output logic                     sdo,
    output logic [N_OUT*N_IN-1:0]    sw_en
);
    localparam int unsigned SEL_W   = $clog2(N_IN);
    localparam int unsigned CHAIN_W = N_OUT * (SEL_W + 1);

    xcfg_op_e               op;
    logic [CHAIN_W-1:0]     chain;
    logic [N_OUT*SEL_W-1:0] lat_sel;
    logic [N_OUT-1:0]       lat_en;

    xcfg_op_decode u_op (
        .ce_n     (ce_n),
        .load_par (load_par),
        .op       (op)
    );

    xcfg_shift_rank #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_rank (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .sdi   (sdi),
        .pdata (pdata),
        .paddr (paddr),
        .chain (chain),
        .sdo   (sdo)
    );

    xcfg_hold_latch #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .upd_n   (upd_n),
        .chain   (chain),
        .lat_sel (lat_sel),
        .lat_en  (lat_en)
    );

    xcfg_switch_decode #(.N_OUT(N_OUT), .N_IN(N_IN), .SEL_W(SEL_W)) u_dec (
        .lat_sel (lat_sel),
        .lat_en  (lat_en),
        .sw_en   (sw_en)
    );
endmodule

// File: tb/tb_xbar_cfg_ctrl.sv
`timescale 1ns/1ps
module tb_xbar_cfg_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ce_n = 1'b1;
    logic         upd_n = 1'b1;
    logic         load_par = 1'b0;
    logic         sdi = 1'b0;
    logic [4:0]   pdata = '0;
    logic [3:0]   paddr = '0;
    logic         sdo;
    logic [255:0] sw_en;

    int ntests = 0;
    int nfail  = 0;

    logic [79:0]  m_chain = '0;
    logic         m_sdo = 1'b0;
    logic         m_known = 1'b0;
    logic         m_sdo_ok = 1'b0;
    logic [3:0]   m_sel [16];
    logic [15:0]  m_en = '0;

    always #2.5 clk = ~clk;

    xbar_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .upd_n(upd_n), .load_par(load_par),
        .sdi(sdi), .pdata(pdata), .paddr(paddr), .sdo(sdo), .sw_en(sw_en)
    );

    function automatic logic [255:0] exp_sw();
        logic [255:0] r = '0;
        for (int o = 0; o < 16; o++)
            for (int i = 0; i < 16; i++)
                r[o*16+i] = m_en[o] && (m_sel[o] == 4'(i));
        return r;
    endfunction

    task automatic chk_vec(input logic [255:0] act, input logic [255:0] exp, input string tag);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: sw_en act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input logic act, input logic exp, input string tag);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: sdo act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chk_rows(input string tag);
        ntests++;
        for (int o = 0; o < 16; o++) begin
            if ($countones(sw_en[o*16 +: 16]) > 1) begin
                nfail++;
                $display("FAIL %s: output %0d act=%h exp=at most one bit", tag, o, sw_en[o*16 +: 16]);
                break;
            end
        end
    endtask

    task automatic step(input logic ce, input logic upd, input logic md, input logic sd,
                        input logic [4:0] pd, input logic [3:0] pa, input logic rst, input string tag);
        @(posedge clk);
        ce_n = ce; upd_n = upd; load_par = md; sdi = sd; pdata = pd; paddr = pa; rst_n = rst;
        @(negedge clk);
        #1;
        if (!ce) begin
            if (!md) begin
                m_sdo = m_chain[79];
                m_chain = {m_chain[78:0], sd};
                if (m_known) m_sdo_ok = 1'b1;
            end else begin
                m_chain[pa*5 +: 5] = pd;
            end
            if (!upd) begin
                for (int o = 0; o < 16; o++) begin
                    m_sel[o] = m_chain[o*5 +: 4];
                    m_en[o]  = m_chain[o*5+4];
                end
            end
        end
        if (!rst) m_en = '0;
        chk_vec(sw_en, exp_sw(), tag);
        chk_rows("R7");
        if (m_sdo_ok) chk_bit(sdo, m_sdo, "R3");
    endtask

    task automatic refresh(input string tag);
        step(1'b0, 1'b0, 1'b1, 1'b0, m_chain[4:0], 4'd0, 1'b1, tag);
    endtask

    initial begin
        #1_000_000;
        nfail++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        logic [79:0]  pat;
        logic [255:0] saved;
        logic [255:0] e;
        logic         sdo_saved;
        void'($urandom(32'h5EED_1234));
        for (int o = 0; o < 16; o++) m_sel[o] = '0;

        // reset state
        repeat (3) @(posedge clk);
        #1;
        chk_vec(sw_en, '0, "R6");

        // R2: directed serial load, index k = shift order
        pat = '0;
        pat[0] = 1; pat[1] = 1; pat[2] = 0; pat[3] = 1; pat[4] = 0;
        pat[75] = 1; pat[76] = 0; pat[77] = 0; pat[78] = 1; pat[79] = 1;
        for (int k = 0; k < 80; k++) step(1'b0, 1'b1, 1'b0, pat[k], 5'd0, 4'd0, 1'b1, "R5");
        m_known = 1'b1;
        refresh("R2");
        e = '0; e[15*16+10] = 1'b1; e[0*16+3] = 1'b1;
        chk_vec(sw_en, e, "R2");

        // R3: a single one travels the chain
        step(1'b0, 1'b1, 1'b0, 1'b1, 5'd0, 4'd0, 1'b1, "R3");
        for (int k = 0; k < 80; k++) step(1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0, 1'b1, "R3");
        chk_bit(sdo, 1'b1, "R3");
        step(1'b0, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0, 1'b1, "R3");
        chk_bit(sdo, 1'b0, "R3");

        // R4: fill every slot in parallel, then isolate one write
        for (int s = 0; s < 16; s++) step(1'b0, 1'b1, 1'b1, 1'b0, {1'b1, 4'(15-s)}, 4'(s), 1'b1, "R4");
        refresh("R4");
        e = '0;
        for (int o = 0; o < 16; o++) e[o*16 + (15-o)] = 1'b1;
        chk_vec(sw_en, e, "R4");
        step(1'b0, 1'b0, 1'b1, 1'b0, 5'b10101, 4'd7, 1'b1, "R4");
        e[7*16+8] = 1'b0; e[7*16+5] = 1'b1;
        chk_vec(sw_en, e, "R4");

        // R1: chip enable high freezes everything
        saved = sw_en; sdo_saved = sdo;
        for (int k = 0; k < 10; k++) begin
            step(1'b1, 1'b0, 1'($urandom), 1'($urandom), 5'($urandom), 4'($urandom), 1'b1, "R1");
            chk_vec(sw_en, saved, "R1");
            chk_bit(sdo, sdo_saved, "R1");
        end

        // R5: staged write is invisible until update
        step(1'b0, 1'b1, 1'b1, 1'b0, 5'b11111, 4'd2, 1'b1, "R5");
        chk_vec(sw_en, saved, "R5");
        refresh("R5");
        saved[2*16+13] = 1'b0; saved[2*16+15] = 1'b1;
        chk_vec(sw_en, saved, "R5");

        // R6: asynchronous clear, no clock edge involved
        @(posedge clk);
        #0.5;
        upd_n = 1'b1; ce_n = 1'b1;
        rst_n = 1'b0;
        #0.5;
        chk_vec(sw_en, '0, "R6");
        m_en = '0;
        @(posedge clk);
        rst_n = 1'b1;
        refresh("R6");
        chk_vec(sw_en, saved, "R6");

        // R8: reset wins over transparent update
        step(1'b0, 1'b0, 1'b1, 1'b0, m_chain[4:0], 4'd0, 1'b0, "R8");
        chk_vec(sw_en, '0, "R8");
        refresh("R8");
        chk_vec(sw_en, saved, "R8");

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            step(1'(($urandom % 4) == 0), 1'(($urandom % 3) != 0), 1'($urandom), 1'($urandom),
                 5'($urandom), 4'($urandom), 1'(($urandom % 40) != 0), "R7");
        end

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule